// File: doc/BRIEF.md
# I2C Master Bit Timer with Clock-Stretch Hold-Off

This block is the timing engine for an I2C master. It times each SCL phase with a down-counting period generator that is reloaded from a 7-bit reload value. It controls the two bus wires only through active-high pull-low enables, so it never drives a line high. It reads the real SCL and SDA levels back through a two-flop synchronizer and samples them once per machine cycle, which is four input clocks.

A single clock-pulse command pulls SCL low for one period and then releases it. The engine then waits until the line actually reads high. Only then does it reload the counter and time the high phase, after which it parks with SCL held low. A slave that keeps SCL low therefore lengthens the high phase instead of shortening it.

A stop command, accepted only while the engine is parked, produces a Stop condition. SCL is held low for one more period and then released. Once SCL reads high, a further period is timed and SDA is released. When SDA reads high, the engine raises a sticky completion flag, clears its stop-busy flag and emits a one-clock interrupt pulse.

Commands are single-cycle control strobes and carry no data, so the block has no valid/ready stream and no back-pressure. A strobe that arrives in a state where it is not accepted is dropped.

Top module: `i2c_stretch_timer`

## Requirements
- R1: After reset, and one clock after `en` is seen low, both pull enables are 0 and `busy`, `stop_busy` and `stop_seen` are 0. Dropping `en` aborts any phase or stop in progress.
- R2: The effective period is max(`reload`, 2) machine cycles, and one machine cycle is 4 clocks. A reload of 0 or 1 behaves as a reload of 2.
- R3: `clk_go`, when idle or parked, pulls SCL low for one period and then releases it. After the high phase the engine parks with SCL pulled low. `sda_pull` is 1 throughout the pulse and while parked.
- R4: While released SCL still reads low, no time is counted and SCL is not pulled again. The bus-level SCL high time from the real rising edge to the next pull is between 4·eff and 4·eff+8 clocks, where eff is the effective period from R2.
- R5: Stop ordering: SCL is held low one period, then released. SDA is released only after SCL has read high for at least 4·eff clocks. SDA is never released while SCL is pulled.
- R6: Once released SDA reads high, `stop_seen` becomes 1, `stop_busy` becomes 0 and `stop_irq` is high for exactly one clock. While another device holds SDA low, none of these happen.
- R7: `stop_go` is ignored when idle and during a clock pulse. `clk_go` is ignored during a stop sequence.
- R8: `stop_seen` stays set until the next accepted command, which clears it one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable; low aborts and releases both lines |
| reload | input | 7 | Period reload value in machine cycles (clamped to at least 2) |
| clk_go | input | 1 | One-clock strobe: generate one SCL clock pulse |
| stop_go | input | 1 | One-clock strobe: generate a Stop condition from parked state |
| scl_in | input | 1 | Level read from the SCL wire |
| sda_in | input | 1 | Level read from the SDA wire |
| scl_pull | output | 1 | 1 = pull SCL low, 0 = release |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |
| busy | output | 1 | A clock pulse or stop sequence is in progress |
| stop_busy | output | 1 | Stop request pending; cleared by hardware on completion |
| stop_seen | output | 1 | Sticky: Stop condition completed |
| stop_irq | output | 1 | One-clock pulse on Stop completion |

## Verification
The hardest situation to reach is a slave stretching SCL for longer than a whole period. The engine must then sit in its released-and-waiting state without counting, and it must time a full high phase only after the wire really rises. The bench models the slave as a second pull-low on each wire. It asserts that pull before a pulse or stop is issued and keeps it for a chosen number of clocks, up to several times the period, after the engine lets go. It then measures the wire's high run directly from the bus model. A separate SDA hold-down during the Stop's final step shows that completion waits for the real line level.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,   // both lines released
    ST_HOLD,   // parked: SCL and SDA pulled low
    ST_LOW,    // timing SCL low phase
    ST_RISE,   // SCL released, waiting to read high
    ST_HIGH,   // timing SCL high phase
    ST_PLOW,   // stop: SCL low one period
    ST_PRISE,  // stop: SCL released, waiting to read high
    ST_PHIGH,  // stop: SCL high one period, SDA still low
    ST_PREL    // stop: SDA released, waiting to read high
  } phase_t;
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '1;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/i2cst_tick.sv
module i2cst_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/i2cst_period.sv
module i2cst_period #(
  parameter int RW  = 7,
  parameter int MIN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [RW-1:0] reload_i,
  output logic          expire_o
);
  localparam logic [RW-1:0] MIN_V = RW'(MIN);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] eff;

  assign eff = (reload_i < MIN_V) ? MIN_V : reload_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                               cnt_q <= '0;
    else if (load_i)                          cnt_q <= eff;
    else if (tick_i && run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;

  assign expire_o = tick_i && run_i && !load_i && (cnt_q == RW'(1));

  // R2: every fresh interval starts at no less than the clamp value
  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q >= MIN_V);
endmodule

// File: rtl/i2c_stretch_timer.sv
module i2c_stretch_timer
  import i2cst_pkg::*;
#(
  parameter int RW          = 7,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RELOAD  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] reload,
  input  logic          clk_go,
  input  logic          stop_go,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_pull,
  output logic          sda_pull,
  output logic          busy,
  output logic          stop_busy,
  output logic          stop_seen,
  output logic          stop_irq
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       tick, load, run, expire;
  logic       accept, stop_acc, done;
  phase_t     state, nxt;

  i2cst_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({sda_in, scl_in}), .q_o(lines_s));
  assign scl_s = lines_s[0];
  assign sda_s = lines_s[1];

  i2cst_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tick_o(tick));

  i2cst_period #(.RW(RW), .MIN(MIN_RELOAD)) u_period (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load), .run_i(run),
    .reload_i(reload), .expire_o(expire));

  assign run = (state == ST_LOW) || (state == ST_HIGH) ||
               (state == ST_PLOW) || (state == ST_PHIGH);

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    accept   = 1'b0;
    stop_acc = 1'b0;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: if (clk_go) begin nxt = ST_LOW; load = 1'b1; accept = 1'b1; end
      ST_HOLD: begin
        if (clk_go) begin
          nxt = ST_LOW; load = 1'b1; accept = 1'b1;
        end else if (stop_go) begin
          nxt = ST_PLOW; load = 1'b1; accept = 1'b1; stop_acc = 1'b1;
        end
      end
      ST_LOW:   if (expire) nxt = ST_RISE;
      ST_RISE:  if (tick && scl_s) begin nxt = ST_HIGH; load = 1'b1; end
      ST_HIGH:  if (expire) nxt = ST_HOLD;
      ST_PLOW:  if (expire) nxt = ST_PRISE;
      ST_PRISE: if (tick && scl_s) begin nxt = ST_PHIGH; load = 1'b1; end
      ST_PHIGH: if (expire) nxt = ST_PREL;
      ST_PREL:  if (tick && sda_s) begin nxt = ST_IDLE; done = 1'b1; end
      default:  nxt = ST_IDLE;
    endcase
    if (!en) begin
      nxt = ST_IDLE; load = 1'b0; accept = 1'b0; stop_acc = 1'b0; done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_IDLE;
      stop_busy <= 1'b0;
      stop_seen <= 1'b0;
      stop_irq  <= 1'b0;
    end else begin
      state    <= nxt;
      stop_irq <= done;
      if (!en)           stop_busy <= 1'b0;
      else if (stop_acc) stop_busy <= 1'b1;
      else if (done)     stop_busy <= 1'b0;
      if (!en)           stop_seen <= 1'b0;
      else if (accept)   stop_seen <= 1'b0;
      else if (done)     stop_seen <= 1'b1;
    end

  assign scl_pull = (state == ST_HOLD) || (state == ST_LOW) || (state == ST_PLOW);
  assign sda_pull = (state != ST_IDLE) && (state != ST_PREL);
  assign busy     = (state != ST_IDLE) && (state != ST_HOLD);

  // R1: disable releases both lines on the next clock
  assert_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_pull && !sda_pull);
  // R4: while released SCL reads low the engine keeps waiting
  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_RISE && !scl_s) |=> state == ST_RISE || !en);
  // R5: SDA is never let go while SCL is pulled
  assert_sda_after_scl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> !scl_pull);
  // R6: interrupt is a single clock wide
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |=> !stop_irq);
  // R6: interrupt coincides with completion flags
  assert_irq_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_irq |-> stop_seen && !stop_busy);
endmodule

// File: tb/i2c_stretch_timer_tb.sv
module i2c_stretch_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] reload = 7'd4;
  logic       clk_go = 1'b0, stop_go = 1'b0;
  logic       slave_scl = 1'b0, slave_sda = 1'b0;
  logic       scl_pull, sda_pull, busy, stop_busy, stop_seen, stop_irq;
  logic       scl_line, sda_line;
  int         n_tests = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign scl_line = !(scl_pull || slave_scl);
  assign sda_line = !(sda_pull || slave_sda);

  i2c_stretch_timer u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
    .clk_go(clk_go), .stop_go(stop_go), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
    .stop_busy(stop_busy), .stop_seen(stop_seen), .stop_irq(stop_irq));

  // bus monitor
  int hi_cnt = 0, last_high = 0, hi_at_rel = 0, irq_cnt = 0;
  logic prev_sda = 1'b0;
  always @(posedge clk) begin
    if (scl_line) hi_cnt <= hi_cnt + 1;
    else begin
      if (hi_cnt != 0) last_high <= hi_cnt;
      hi_cnt <= 0;
    end
    prev_sda <= sda_pull;
    if (prev_sda && !sda_pull) hi_at_rel <= hi_cnt;
    if (stop_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_clk();
    @(negedge clk) clk_go = 1'b1;
    @(negedge clk) clk_go = 1'b0;
  endtask

  task automatic strobe_stop();
    @(negedge clk) stop_go = 1'b1;
    @(negedge clk) stop_go = 1'b0;
  endtask

  task automatic wait_scl_pull(input logic v);
    for (int i = 0; i < 3000; i++) begin
      if (scl_pull == v) break;
      @(negedge clk);
    end
  endtask

  function automatic int eff_of(input int r);
    return (r < 2) ? 2 : r;
  endfunction

  // one clock pulse with optional slave stretch, measures high time
  task automatic t_pulse(input int r, input int stretch, input string tag);
    int e;
    e = eff_of(r);
    @(negedge clk) reload = 7'(r);
    if (stretch > 0) slave_scl = 1'b1;
    strobe_clk();
    chk(scl_pull && sda_pull, {tag, " R3 pulls asserted in low phase"}, {scl_pull, sda_pull}, 3);
    wait_scl_pull(1'b0);
    if (stretch > 0) begin
      repeat (stretch) @(negedge clk);
      chk(!scl_pull && busy, {tag, " R4 waits while stretched"}, {scl_pull, busy}, 1);
      slave_scl = 1'b0;
    end
    wait_scl_pull(1'b1);
    repeat (2) @(negedge clk);
    chk(last_high >= 4*e && last_high <= 4*e + 8, {tag, " R4 high time"}, last_high, 4*e);
    chk(scl_pull && sda_pull && !busy, {tag, " R3 parked low"}, {scl_pull, sda_pull, busy}, 6);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy && !stop_busy && !stop_seen && !stop_irq,
        "R1 reset state", {scl_pull, sda_pull, busy, stop_busy, stop_seen}, 0);
  endtask

  task automatic t_stop(input int r, input int scl_hold, input int sda_hold, input string tag);
    int e, irq0;
    e = eff_of(r);
    t_pulse(r, 0, {tag, " pre"});
    irq0 = irq_cnt;
    if (scl_hold > 0) slave_scl = 1'b1;
    strobe_stop();
    chk(stop_busy && !stop_seen, {tag, " R8 stop accepted"}, {stop_busy, stop_seen}, 2);
    // clk_go during stop must be ignored
    strobe_clk();
    wait_scl_pull(1'b0);
    chk(sda_pull, {tag, " R5 SDA held when SCL released"}, sda_pull, 1);
    if (scl_hold > 0) begin
      repeat (scl_hold) @(negedge clk);
      chk(sda_pull && stop_busy, {tag, " R5 SDA held while stretched"}, sda_pull, 1);
      slave_scl = 1'b0;
    end
    if (sda_hold > 0) slave_sda = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (!sda_pull) break;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
    chk(hi_at_rel >= 4*e, {tag, " R5 SCL high before SDA release"}, hi_at_rel, 4*e);
    if (sda_hold > 0) begin
      repeat (sda_hold) @(negedge clk);
      chk(!stop_seen && stop_busy && irq_cnt == irq0, {tag, " R6 waits on held SDA"},
          {stop_seen, stop_busy}, 1);
      slave_sda = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (!stop_busy) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(stop_seen && !stop_busy, {tag, " R6 flags"}, {stop_seen, stop_busy}, 2);
    chk(irq_cnt == irq0 + 1, {tag, " R6 one irq clock"}, irq_cnt - irq0, 1);
    repeat (40) @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy, {tag, " R7 clk_go during stop ignored"},
        {scl_pull, sda_pull, busy}, 0);
  endtask

  task automatic t_stop_in_pulse();
    @(negedge clk) reload = 7'd5;
    strobe_clk();
    strobe_stop();
    wait_scl_pull(1'b0);
    wait_scl_pull(1'b1);
    repeat (40) @(negedge clk);
    chk(scl_pull && !stop_busy, "R7 stop_go during pulse ignored", {scl_pull, stop_busy}, 2);
  endtask

  task automatic t_stop_idle();
    logic seen0;
    seen0 = stop_seen;
    strobe_stop();
    repeat (30) @(negedge clk);
    chk(!stop_busy && !scl_pull && !sda_pull && stop_seen == seen0,
        "R7 stop_go when idle ignored", {stop_busy, scl_pull, sda_pull}, 0);
  endtask

  task automatic t_seen_clear();
    chk(stop_seen, "R8 seen sticky before command", stop_seen, 1);
    strobe_clk();
    chk(!stop_seen, "R8 seen cleared by clk_go", stop_seen, 0);
    wait_scl_pull(1'b0);
    wait_scl_pull(1'b1);
  endtask

  task automatic t_abort();
    strobe_clk();
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!scl_pull && !sda_pull && !busy && !stop_busy, "R1 disable aborts",
        {scl_pull, sda_pull, busy}, 0);
    en = 1'b1;
    repeat (10) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R1 stays released after re-enable", {scl_pull, sda_pull}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    en = 1'b1;
    repeat (4) @(negedge clk);
    t_pulse(0, 0, "R2 clamp0");
    t_pulse(1, 0, "R2 clamp1");
    t_pulse(20, 0, "R2 r20");
    t_pulse(5, 60, "R4 long stretch");
    for (int k = 0; k < 4; k++) begin
      t_pulse(int'($urandom_range(10, 3)), int'($urandom_range(70, 3)), "R4 random stretch");
    end
    t_stop_in_pulse();
    t_stop(6, 0, 0, "stop plain");
    t_stop_idle();
    t_seen_clear();
    t_stop(4, 50, 30, "stop stretched");
    t_abort();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule